// File: doc/BRIEF.md
# Paired-Page Parity Backup Engine

This block sits in the write and recovery path of a multi-level-cell flash controller. When two least-significant-bit pages have to be protected against a later most-significant-bit program that fails, it can produce one backup page that is the bitwise XOR of both pages. It can also produce a plain copy of a single page. Each backup it emits comes with a spare-area record: the logical page number, the physical page number, and a flag that marks the page as parity or plain.

In recovery, the controller supplies the corrupted page's identity, whether that page is present in the logical-to-physical map, and the spare record of a candidate backup page. The block checks the candidate first. If the record matches and carries the parity flag, the block XORs the backup words with the words of the surviving partner page, which rebuilds the lost page. If the record matches and the flag is clear, the backup words pass through unchanged. If the record does not match, or the page is not mapped, the block reports a status code and moves no data.

Page data enters and leaves on valid/ready word streams, with a last marker on the final word. A one-cycle status pulse ends every command.

Top module: `pbk_parity_engine`

## Requirements
- R1: After reset, out_valid, sts_valid and in_ready are low and cmd_ready is high.
- R2: Command op 1 (parity generate) emits in_word_a XOR in_word_b for each input word, and presents rec_lpn/rec_ppn equal to cmd_lpn/cmd_ppn with rec_pflag = 1.
- R3: Command op 0 (plain copy) emits in_word_a unchanged, with rec_pflag = 0 and rec_lpn/rec_ppn taken from the command.
- R4: Command op 2 (recover) with a matching backup record whose flag is set emits in_word_a (backup) XOR in_word_b (surviving partner), with rec_pflag = 1.
- R5: Recover with a matching backup record whose flag is clear emits in_word_a unchanged, with rec_pflag = 0.
- R6: A recover command is accepted for data only when bkp_lpn equals cmd_lpn and bkp_ppn equals cmd_ppn. A difference in either field ends the command with sts_code 2 (no match), one cycle after acceptance, and no data is taken or produced.
- R7: A recover command with cmd_mapped low ends with sts_code 1 (unmapped) and moves no data. This check takes priority over the record comparison.
- R8: Op 3 is reserved. It ends with sts_code 3 and moves no data.
- R9: out_last is high only on the output word that entered with in_last. While out_valid is high and out_ready is low, out_word and out_last hold.
- R10: A page command ends with sts_valid high and sts_code 0 in the cycle after the last output word is taken. cmd_ready is high in that same cycle.
- R11: in_ready is never high while the block waits for a command or is rejecting one.
- R12: With out_ready held high and input offered every cycle, an N-word page moves one word per cycle, and status arrives N+1 cycles after the first input word is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if offered |
| cmd_op | input | 2 | 0 plain copy, 1 parity generate, 2 recover, 3 reserved |
| cmd_lpn | input | LPN_W | Logical page number of the page being backed up or recovered |
| cmd_ppn | input | PPN_W | Physical page number of the page being backed up or recovered |
| cmd_mapped | input | 1 | Recover: the corrupted page has an entry in the map |
| bkp_lpn | input | LPN_W | Recover: logical page number in the backup's spare record |
| bkp_ppn | input | PPN_W | Recover: physical page number in the backup's spare record |
| bkp_pflag | input | 1 | Recover: parity flag in the backup's spare record |
| in_valid | input | 1 | Input word pair valid |
| in_ready | output | 1 | Input word pair taken when valid |
| in_word_a | input | DATA_W | First page word (generate) or backup word (recover) |
| in_word_b | input | DATA_W | Second page word (generate) or surviving partner word (recover) |
| in_last | input | 1 | Final word pair of the page |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Output word taken when valid |
| out_word | output | DATA_W | Backup or recovered page word |
| out_last | output | 1 | Final output word of the page |
| rec_lpn | output | LPN_W | Spare record logical page number |
| rec_ppn | output | PPN_W | Spare record physical page number |
| rec_pflag | output | 1 | Spare record parity flag |
| sts_valid | output | 1 | One-cycle end-of-command pulse |
| sts_code | output | 2 | 0 done, 1 unmapped, 2 no match, 3 reserved op |

## Verification
The assertions check the stream protocol on every cycle: the output holds while it is stalled, input is never taken while the block is idle or rejecting, a done status always follows a last-word handshake, and a rejection always follows an accepted command, with the unmapped case taking priority. Only the bench scenarios can show that the word contents are correct for each mode. The same holds for the spare record's values, the mismatch on a single field, the single-word page, and the one-word-per-cycle throughput.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN   = 2'd0,
    OP_PARITY  = 2'd1,
    OP_RECOVER = 2'd2,
    OP_RSVD    = 2'd3
  } pbk_op_e;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_UNMAPPED = 2'd1,
    ST_NOMATCH  = 2'd2,
    ST_BADOP    = 2'd3
  } pbk_sts_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_STREAM = 2'd1,
    S_DRAIN  = 2'd2
  } pbk_state_e;

endpackage

// File: rtl/pbk_ctrl.sv
module pbk_ctrl
  import pbk_pkg::*;
#(
  parameter int LPN_W = 20,
  parameter int PPN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [LPN_W-1:0] cmd_lpn,
  input  logic [PPN_W-1:0] cmd_ppn,
  input  logic             cmd_mapped,
  input  logic [LPN_W-1:0] bkp_lpn,
  input  logic [PPN_W-1:0] bkp_ppn,
  input  logic             bkp_pflag,
  input  logic             in_fire_last,
  input  logic             out_fire_last,
  output logic             idle,
  output logic             streaming,
  output logic [LPN_W-1:0] rec_lpn,
  output logic [PPN_W-1:0] rec_ppn,
  output logic             rec_pflag,
  output logic             sts_valid,
  output logic [1:0]       sts_code
);

  pbk_state_e       state_q, state_d;
  logic [LPN_W-1:0] lpn_q;
  logic [PPN_W-1:0] ppn_q;
  logic             pflag_q, pflag_d;
  logic             rec_en;
  logic             sts_v_q, sts_v_d;
  pbk_sts_e         sts_q, sts_d;
  logic             rec_match;

  assign rec_match = (cmd_lpn == bkp_lpn) && (cmd_ppn == bkp_ppn);

  always_comb begin
    state_d = state_q;
    pflag_d = pflag_q;
    rec_en  = 1'b0;
    sts_v_d = 1'b0;
    sts_d   = sts_q;
    unique case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          rec_en = 1'b1;
          case (cmd_op)
            OP_PLAIN: begin
              state_d = S_STREAM;
              pflag_d = 1'b0;
            end
            OP_PARITY: begin
              state_d = S_STREAM;
              pflag_d = 1'b1;
            end
            OP_RECOVER: begin
              pflag_d = bkp_pflag;
              if (!cmd_mapped) begin
                sts_v_d = 1'b1;
                sts_d   = ST_UNMAPPED;
              end else if (!rec_match) begin
                sts_v_d = 1'b1;
                sts_d   = ST_NOMATCH;
              end else begin
                state_d = S_STREAM;
              end
            end
            default: begin
              pflag_d = 1'b0;
              sts_v_d = 1'b1;
              sts_d   = ST_BADOP;
            end
          endcase
        end
      end
      S_STREAM: begin
        if (in_fire_last) state_d = S_DRAIN;
      end
      S_DRAIN: begin
        if (out_fire_last) begin
          state_d = S_IDLE;
          sts_v_d = 1'b1;
          sts_d   = ST_OK;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sts_v_q <= 1'b0;
      sts_q   <= ST_OK;
      lpn_q   <= '0;
      ppn_q   <= '0;
      pflag_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sts_v_q <= sts_v_d;
      if (sts_v_d) sts_q <= sts_d;
      if (rec_en) begin
        lpn_q   <= cmd_lpn;
        ppn_q   <= cmd_ppn;
        pflag_q <= pflag_d;
      end
    end
  end

  assign idle      = (state_q == S_IDLE);
  assign streaming = (state_q == S_STREAM);
  assign rec_lpn   = lpn_q;
  assign rec_ppn   = ppn_q;
  assign rec_pflag = pflag_q;
  assign sts_valid = sts_v_q;
  assign sts_code  = sts_q;

  AST_OK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_v_q && sts_q == ST_OK) |-> $past(out_fire_last)); // R10

  AST_REJECT_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_v_q && sts_q != ST_OK) |-> $past(cmd_valid && state_q == S_IDLE)); // R6

  AST_UNMAPPED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_v_q && sts_q == ST_NOMATCH) |-> $past(cmd_mapped)); // R7

endmodule

// File: rtl/pbk_combine.sv
module pbk_combine #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              xor_en,
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  output logic [DATA_W-1:0] word_y
);

  localparam int LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l;
    assign a_l = word_a[g*LANE_W +: LANE_W];
    assign b_l = word_b[g*LANE_W +: LANE_W];
    assign word_y[g*LANE_W +: LANE_W] = xor_en ? (a_l ^ b_l) : a_l;
  end

endmodule

// File: rtl/pbk_out_stage.sv
module pbk_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] d_word,
  input  logic              d_last,
  output logic              room,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_word,
  output logic              q_last
);

  logic              v_q, v_d;
  logic [DATA_W-1:0] w_q;
  logic              l_q;

  assign room = !v_q || q_ready;

  always_comb begin
    v_d = v_q;
    if (take)         v_d = 1'b1;
    else if (q_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      w_q <= '0;
      l_q <= 1'b0;
    end else begin
      v_q <= v_d;
      if (take) begin
        w_q <= d_word;
        l_q <= d_last;
      end
    end
  end

  assign q_valid = v_q;
  assign q_word  = w_q;
  assign q_last  = l_q;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !q_ready) |=> (v_q && $stable(w_q) && $stable(l_q))); // R9

endmodule

// File: rtl/pbk_parity_engine.sv
module pbk_parity_engine #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int LPN_W  = 20,
  parameter int PPN_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [LPN_W-1:0]  cmd_lpn,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic              cmd_mapped,
  input  logic [LPN_W-1:0]  bkp_lpn,
  input  logic [PPN_W-1:0]  bkp_ppn,
  input  logic              bkp_pflag,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word_a,
  input  logic [DATA_W-1:0] in_word_b,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_word,
  output logic              out_last,
  output logic [LPN_W-1:0]  rec_lpn,
  output logic [PPN_W-1:0]  rec_ppn,
  output logic              rec_pflag,
  output logic              sts_valid,
  output logic [1:0]        sts_code
);

  logic              idle, streaming, room;
  logic              in_fire, in_fire_last, out_fire_last;
  logic [DATA_W-1:0] mix_word;

  assign in_ready      = streaming && room;
  assign in_fire       = in_valid && in_ready;
  assign in_fire_last  = in_fire && in_last;
  assign out_fire_last = out_valid && out_ready && out_last;
  assign cmd_ready     = idle;

  pbk_ctrl #(.LPN_W(LPN_W), .PPN_W(PPN_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_lpn      (cmd_lpn),
    .cmd_ppn      (cmd_ppn),
    .cmd_mapped   (cmd_mapped),
    .bkp_lpn      (bkp_lpn),
    .bkp_ppn      (bkp_ppn),
    .bkp_pflag    (bkp_pflag),
    .in_fire_last (in_fire_last),
    .out_fire_last(out_fire_last),
    .idle         (idle),
    .streaming    (streaming),
    .rec_lpn      (rec_lpn),
    .rec_ppn      (rec_ppn),
    .rec_pflag    (rec_pflag),
    .sts_valid    (sts_valid),
    .sts_code     (sts_code)
  );

  pbk_combine #(.DATA_W(DATA_W), .LANE_W(LANE_W)) comb_i (
    .xor_en(rec_pflag),
    .word_a(in_word_a),
    .word_b(in_word_b),
    .word_y(mix_word)
  );

  pbk_out_stage #(.DATA_W(DATA_W)) ostg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (in_fire),
    .d_word (mix_word),
    .d_last (in_last),
    .room   (room),
    .q_valid(out_valid),
    .q_ready(out_ready),
    .q_word (out_word),
    .q_last (out_last)
  );

  AST_NO_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cmd_ready); // R11

endmodule

// File: tb/pbk_parity_engine_tb_top.sv
module pbk_parity_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int LPN_W  = 20;
  localparam int PPN_W  = 24;

  logic              clk;
  logic              rst_n;
  logic              cmd_valid, cmd_ready;
  logic [1:0]        cmd_op;
  logic [LPN_W-1:0]  cmd_lpn, bkp_lpn, rec_lpn;
  logic [PPN_W-1:0]  cmd_ppn, bkp_ppn, rec_ppn;
  logic              cmd_mapped, bkp_pflag, rec_pflag;
  logic              in_valid, in_ready, in_last;
  logic [DATA_W-1:0] in_word_a, in_word_b, out_word;
  logic              out_valid, out_ready, out_last;
  logic              sts_valid;
  logic [1:0]        sts_code;

  int n_chk;
  int n_bad;

  pbk_parity_engine #(.DATA_W(DATA_W), .LANE_W(8), .LPN_W(LPN_W), .PPN_W(PPN_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_lpn(cmd_lpn), .cmd_ppn(cmd_ppn), .cmd_mapped(cmd_mapped),
    .bkp_lpn(bkp_lpn), .bkp_ppn(bkp_ppn), .bkp_pflag(bkp_pflag),
    .in_valid(in_valid), .in_ready(in_ready), .in_word_a(in_word_a),
    .in_word_b(in_word_b), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_last(out_last),
    .rec_lpn(rec_lpn), .rec_ppn(rec_ppn), .rec_pflag(rec_pflag),
    .sts_valid(sts_valid), .sts_code(sts_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(input int seed, input int idx);
    return DATA_W'((seed * 32'h9E3779B1) ^ (idx * 32'h7F4A7C15) ^ (idx << 3));
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  task automatic t_reset_state();
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(sts_valid == 1'b0, "R1 sts_valid", sts_valid, 0);
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
  endtask

  // Runs one accepted page command; pat 0 = no gaps, pat 1 = input gaps and output stalls.
  task automatic t_page(input logic [1:0] op, input logic pflag, input int n, input int pat,
                        input int seed, input string tag);
    int ii, oo, cyc;
    bit done, use_xor;
    logic [DATA_W-1:0] exp_w;
    use_xor = (op == 2'd1) || (op == 2'd2 && pflag);
    cmd_op = op; cmd_lpn = LPN_W'(seed + 7); cmd_ppn = PPN_W'(seed * 3 + 1);
    cmd_mapped = 1'b1; bkp_lpn = LPN_W'(seed + 7); bkp_ppn = PPN_W'(seed * 3 + 1);
    bkp_pflag = pflag; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk(rec_lpn == LPN_W'(seed + 7), {tag, " rec_lpn"}, rec_lpn, seed + 7);
    chk(rec_ppn == PPN_W'(seed * 3 + 1), {tag, " rec_ppn"}, rec_ppn, seed * 3 + 1);
    chk(rec_pflag == use_xor, {tag, " rec_pflag"}, rec_pflag, use_xor);
    ii = 0; oo = 0; cyc = 0; done = 0;
    while (!done && cyc < 400) begin
      in_valid  = (ii < n) && !(pat == 1 && (cyc % 4) == 1);
      in_word_a = word_of(seed, ii);
      in_word_b = word_of(seed + 1000, ii);
      in_last   = (ii == n - 1);
      out_ready = !(pat == 1 && (cyc % 3) == 0);
      #1;
      if (sts_valid) begin
        chk(sts_code == 2'd0, "R10 status done", sts_code, 0);
        chk(oo == n, "R10 word count", oo, n);
        chk(cmd_ready == 1'b1, "R10 cmd_ready", cmd_ready, 1);
        if (pat == 0) chk(cyc == n + 1, "R12 throughput cycles", cyc, n + 1);
        done = 1;
      end
      if (out_valid && out_ready) begin
        exp_w = use_xor ? (word_of(seed, oo) ^ word_of(seed + 1000, oo)) : word_of(seed, oo);
        chk(out_word == exp_w, {tag, " word"}, out_word, exp_w);
        chk(out_last == (oo == n - 1), "R9 out_last", out_last, oo == n - 1);
        oo++;
      end
      if (in_valid && in_ready) ii++;
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    chk(done, {tag, " completion"}, done, 1);
  endtask

  task automatic t_reject(input logic [1:0] op, input logic mapped, input logic lpn_off,
                          input logic ppn_off, input logic [1:0] exp_code, input string tag);
    cmd_op = op; cmd_lpn = 20'h1234; cmd_ppn = 24'h00ABCD; cmd_mapped = mapped;
    bkp_lpn = 20'h1234 ^ LPN_W'(lpn_off); bkp_ppn = 24'h00ABCD ^ PPN_W'({ppn_off, 4'h0});
    bkp_pflag = 1'b1; cmd_valid = 1'b1;
    in_valid = 1'b1; in_word_a = 32'hDEAD_BEEF; in_word_b = 32'h0; in_last = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk(sts_valid == 1'b1, {tag, " sts_valid"}, sts_valid, 1);
    chk(sts_code == exp_code, {tag, " sts_code"}, sts_code, exp_code);
    for (int k = 0; k < 3; k++) begin
      chk(in_ready == 1'b0, "R11 in_ready while rejecting", in_ready, 0);
      chk(out_valid == 1'b0, {tag, " no output"}, out_valid, 0);
      @(posedge clk); @(negedge clk); #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_lpn = '0; cmd_ppn = '0;
    cmd_mapped = 1'b0; bkp_lpn = '0; bkp_ppn = '0; bkp_pflag = 1'b0;
    in_valid = 1'b0; in_word_a = '0; in_word_b = '0; in_last = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset_state();                                   // R1
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R11 in_ready idle", in_ready, 0);
    t_page(2'd1, 1'b0, 8, 0, 11, "R2 parity gen");     // R2, R12
    t_page(2'd1, 1'b0, 6, 1, 23, "R2 parity gen stalled"); // R2, R9
    t_page(2'd0, 1'b0, 5, 0, 37, "R3 plain copy");     // R3
    t_page(2'd2, 1'b1, 7, 1, 41, "R4 recover parity"); // R4
    t_page(2'd2, 1'b0, 4, 0, 53, "R5 recover plain");  // R5
    t_page(2'd1, 1'b0, 1, 0, 67, "R9 single word");    // R9
    t_reject(2'd2, 1'b1, 1'b1, 1'b0, 2'd2, "R6 lpn mismatch");
    t_reject(2'd2, 1'b1, 1'b0, 1'b1, 2'd2, "R6 ppn mismatch");
    t_reject(2'd2, 1'b0, 1'b1, 1'b1, 2'd1, "R7 unmapped");
    t_reject(2'd3, 1'b1, 1'b0, 1'b0, 2'd3, "R8 reserved op");
    t_page(2'd2, 1'b1, 3, 0, 79, "R4 recover after reject");
    finish_run();
  end

endmodule